// File: doc/BRIEF.md
# Serial Frequency-Word Loader

This block accepts a 24-bit frequency and output-control word over a three-wire serial port: a serial clock, a serial data line and an active-low chip select. A bit counter frames each transfer. Dropping the chip select starts a transfer, and bits are taken least significant first on rising serial clock edges. The word is committed on the edge that delivers the 24th bit. Any later bits are ignored until the chip select goes high again. A transfer that ends early is thrown away, and the committed word is left untouched.

The committed word lives in the serial clock domain. It is carried into the system clock domain by a toggle handshake, so every field updates on the same system clock edge. That edge also produces a one-cycle update strobe. The system-side copy is split into fields for the divider and output logic:

- feedback divider
- reference divider
- prescale select
- two output divider codes
- two output enables
- a reference bypass select

A sticky flag records any committed word whose dividers are below 3 or whose reserved bits are not set.

Top module: `freq_word_loader`

## Requirements
- R1: After reset, cfgWord equals the parameter defaults: bits 19, 20, 21 and 23 are 1 and bit 22 is 0. updStrobe and cfgErr are 0.
- R2: A falling csN arms the transfer. sData is sampled on each rising sClk while csN is low, and the first bit becomes bit 0, the second bit 1, and so on up to bit 23.
- R3: The 24th rising sClk of a transfer commits the word. cfgWord shows it from the third system clock edge after that sClk edge, and keeps its previous value before then.
- R4: Rising sClk edges after the 24th do not alter the committed word and do not cause a second commit, until csN returns high.
- R5: If csN rises before 24 bits have arrived, cfgWord is unchanged and no strobe occurs. The bit counter clears while csN is high, so the next transfer starts again at bit 0.
- R6: Each commit gives exactly one updStrobe pulse, one system clock cycle wide, on the same edge that updates cfgWord.
- R7: All fields of cfgWord change together, and only on an edge where updStrobe is raised.
- R8: The field outputs decode cfgWord as follows:
  - fbDiv = bits 6..0
  - refDiv = bits 13..7
  - preScale = bit 14
  - clkxCode = bits 16..15
  - vcoCode = bits 18..17
  - clkEn = bit 19
  - clkxEn = bit 20
  - refSel = bit 22
- R9: cfgErr is set when a committed word has fbDiv < 3, refDiv < 3, bit 21 = 0 or bit 23 = 0. That word is still committed. cfgErr stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| sClk | input | 1 | Serial clock, rising edge samples data |
| csN | input | 1 | Active-low chip select framing a transfer |
| sData | input | 1 | Serial data, bit 0 first |
| cfgWord | output | 24 | Committed word in the system domain |
| fbDiv | output | 7 | Feedback divider field |
| refDiv | output | 7 | Reference divider field |
| preScale | output | 1 | Prescale select (1 = divide by 8) |
| clkxCode | output | 2 | Secondary output divider code |
| vcoCode | output | 2 | VCO output divider code |
| clkEn | output | 1 | Main output enable |
| clkxEn | output | 1 | Secondary output enable |
| refSel | output | 1 | Route reference onto main output |
| updStrobe | output | 1 | One-cycle pulse on each commit |
| cfgErr | output | 1 | Sticky invalid-word flag |

## Verification
The commit toggle passes through two synchroniser flops and then the capture register. cfgWord and updStrobe are therefore due on the third system clock edge after the 24th rising sClk, with one edge of slack for the phase between the two clocks. The latency scenario polls falling system clock edges after that sClk edge. It requires the old word on every poll before the strobe, and requires the strobe to appear in the second to fourth poll. All other scenarios wait eight system cycles after csN rises and then sample, once every output must have settled. Strobe pulses and their widths are counted continuously at falling clock edges, so a missing, doubled or stretched strobe is caught.

// File: rtl/sfwl_pkg.sv
package sfwl_pkg;

  localparam int WORD_W = 24;

  typedef struct packed {
    logic shiftEn;   // serial domain: take a bit
    logic commit;    // serial domain: this edge completes the word
    logic capture;   // system domain: load the new word
  } strobe_t;

  typedef struct packed {
    logic       rsvdHi;
    logic       refSel;
    logic       rsvdLo;
    logic       clkxEn;
    logic       clkEn;
    logic [1:0] vcoCode;
    logic [1:0] clkxCode;
    logic       preScale;
    logic [6:0] refDiv;
    logic [6:0] fbDiv;
  } cfg_t;

  function automatic logic wordBad(input logic [WORD_W-1:0] w);
    cfg_t c;
    c = cfg_t'(w);
    return (c.fbDiv < 7'd3) || (c.refDiv < 7'd3) || !c.rsvdLo || !c.rsvdHi;
  endfunction

endpackage

// File: rtl/sfwl_ctrl.sv
module sfwl_ctrl
  import sfwl_pkg::*;
#(
  parameter int BITS        = WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sClk,
  input  logic    csN,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  logic [CNT_W-1:0] bitCnt;
  logic             commitTgl;
  logic [SYNC_STAGES:0] syncQ;

  // bit counter: cleared asynchronously whenever the select is idle
  always_ff @(posedge sClk or posedge csN or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (csN)           bitCnt <= '0;
    else if (bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strb.shiftEn = !csN && (bitCnt < FULL);
    strb.commit  = !csN && (bitCnt == LAST);
  end

  // commit event as a level toggle for the crossing
  always_ff @(posedge sClk or negedge rstN) begin
    if (!rstN)            commitTgl <= 1'b0;
    else if (strb.commit) commitTgl <= ~commitTgl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], commitTgl};
  end

  assign strb.capture = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  // R4: once the word is full, further edges cause no commit
  a_r4_no_commit_after_full: assert property (@(posedge sClk) disable iff (!rstN || csN)
    (bitCnt == FULL) |=> $stable(commitTgl));

  // R3: counter never runs past the word length
  a_r3_cnt_bounded: assert property (@(posedge sClk) disable iff (!rstN)
    bitCnt <= FULL);

endmodule

// File: rtl/sfwl_datapath.sv
module sfwl_datapath
  import sfwl_pkg::*;
#(
  parameter int               BITS     = WORD_W,
  parameter logic [BITS-1:0]  DEF_WORD = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sClk,
  input  logic            sData,
  input  strobe_t         strb,
  output logic [BITS-1:0] cfgWord,
  output logic            updStrobe,
  output logic            cfgErr
);

  logic [BITS-1:0] shiftQ;
  logic [BITS-1:0] holdQ;
  logic [BITS-1:0] nextShift;

  assign nextShift = {sData, shiftQ[BITS-1:1]};

  always_ff @(posedge sClk or negedge rstN) begin
    if (!rstN)             shiftQ <= '0;
    else if (strb.shiftEn) shiftQ <= nextShift;
  end

  // committed word, stable between commits for the crossing
  always_ff @(posedge sClk or negedge rstN) begin
    if (!rstN)            holdQ <= DEF_WORD;
    else if (strb.commit) holdQ <= nextShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord   <= DEF_WORD;
      updStrobe <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      updStrobe <= strb.capture;
      if (strb.capture) begin
        cfgWord <= holdQ;
        if (wordBad(holdQ)) cfgErr <= 1'b1;
      end
    end
  end

  // R7: the word moves only together with the strobe
  a_r7_word_moves_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |-> $stable(cfgWord));

  // R6: strobe is a single-cycle pulse
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe);

  // R9: flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R9: a bad committed word is flagged on its arrival
  a_r9_err_on_bad: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && wordBad(cfgWord)) |-> cfgErr);

endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader
  import sfwl_pkg::*;
#(
  parameter logic [6:0] DEF_FB      = 7'd60,
  parameter logic [6:0] DEF_REF     = 7'd17,
  parameter logic       DEF_PRE     = 1'b0,
  parameter logic [1:0] DEF_XCODE   = 2'd2,
  parameter logic [1:0] DEF_VCODE   = 2'd1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sClk,
  input  logic              csN,
  input  logic              sData,
  output logic [WORD_W-1:0] cfgWord,
  output logic [6:0]        fbDiv,
  output logic [6:0]        refDiv,
  output logic              preScale,
  output logic [1:0]        clkxCode,
  output logic [1:0]        vcoCode,
  output logic              clkEn,
  output logic              clkxEn,
  output logic              refSel,
  output logic              updStrobe,
  output logic              cfgErr
);

  localparam logic [WORD_W-1:0] DEF_WORD =
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, DEF_VCODE, DEF_XCODE, DEF_PRE, DEF_REF, DEF_FB};

  strobe_t strb;
  cfg_t    cfgView;

  sfwl_ctrl #(.BITS(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .sClk(sClk),
    .csN (csN),
    .strb(strb)
  );

  sfwl_datapath #(.BITS(WORD_W), .DEF_WORD(DEF_WORD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sClk     (sClk),
    .sData    (sData),
    .strb     (strb),
    .cfgWord  (cfgWord),
    .updStrobe(updStrobe),
    .cfgErr   (cfgErr)
  );

  assign cfgView  = cfg_t'(cfgWord);
  assign fbDiv    = cfgView.fbDiv;
  assign refDiv   = cfgView.refDiv;
  assign preScale = cfgView.preScale;
  assign clkxCode = cfgView.clkxCode;
  assign vcoCode  = cfgView.vcoCode;
  assign clkEn    = cfgView.clkEn;
  assign clkxEn   = cfgView.clkxEn;
  assign refSel   = cfgView.refSel;

endmodule

// File: tb/freq_word_loader_tb.sv
`timescale 1ns/1ps
module freq_word_loader_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sClk = 1'b0;
  logic csN = 1'b1;
  logic sData = 1'b0;
  logic [23:0] cfgWord;
  logic [6:0] fbDiv, refDiv;
  logic preScale, clkEn, clkxEn, refSel, updStrobe, cfgErr;
  logic [1:0] clkxCode, vcoCode;

  int checks = 0;
  int failures = 0;
  int strobeCnt = 0;
  int wideCnt = 0;
  bit prevStrobe = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  freq_word_loader u_dut (
    .clk(clk), .rstN(rstN), .sClk(sClk), .csN(csN), .sData(sData),
    .cfgWord(cfgWord), .fbDiv(fbDiv), .refDiv(refDiv), .preScale(preScale),
    .clkxCode(clkxCode), .vcoCode(vcoCode), .clkEn(clkEn), .clkxEn(clkxEn),
    .refSel(refSel), .updStrobe(updStrobe), .cfgErr(cfgErr)
  );

  always @(negedge clk) begin
    if (updStrobe) strobeCnt++;
    if (updStrobe && prevStrobe) wideCnt++;
    prevStrobe = updStrobe;
  end

  function automatic logic [23:0] pack(input logic [6:0] n, input logic [6:0] m,
      input logic p, input logic [1:0] x, input logic [1:0] v,
      input logic ce, input logic cxe, input logic rs);
    return {1'b1, rs, 1'b1, cxe, ce, v, x, p, m, n};
  endfunction

  localparam logic [23:0] DEFW = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd2, 1'b0, 7'd17, 7'd60};

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sclkPulse(input logic b);
    sData = b;
    #5 sClk = 1'b1;
    #10 sClk = 1'b0;
    #5;
  endtask

  task automatic sendWord(input logic [23:0] w, input int nBits);
    csN = 1'b0;
    #12;
    for (int i = 0; i < nBits; i++) sclkPulse(i < 24 ? w[i] : ~w[i % 24]);
    #7 csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkFields(input logic [23:0] e, input string req);
    check(fbDiv == e[6:0], req, {17'd0, fbDiv}, {17'd0, e[6:0]});
    check(refDiv == e[13:7], req, {17'd0, refDiv}, {17'd0, e[13:7]});
    check({vcoCode, clkxCode, preScale} == e[18:14], req,
          {19'd0, vcoCode, clkxCode, preScale}, {19'd0, e[18:14]});
    check({refSel, clkxEn, clkEn} == {e[22], e[20], e[19]}, req,
          {21'd0, refSel, clkxEn, clkEn}, {21'd0, e[22], e[20], e[19]});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    check(cfgWord == DEFW, "R1 default word", cfgWord, DEFW);
    check(!updStrobe && !cfgErr, "R1 strobe/err idle", {22'd0, updStrobe, cfgErr}, 24'd0);
    checkFields(DEFW, "R1/R8 default fields");
  endtask

  task automatic t_full(input logic [23:0] w);
    int base;
    base = strobeCnt;
    sendWord(w, 24);
    check(cfgWord == w, "R2 lsb-first word", cfgWord, w);
    check(strobeCnt == base + 1, "R6 one strobe per commit", 24'(strobeCnt - base), 24'd1);
    checkFields(w, "R8 field decode");
  endtask

  task automatic t_latency(input logic [23:0] w);
    logic [23:0] old;
    int seen;
    old = cfgWord;
    seen = 0;
    csN = 1'b0;
    #12;
    for (int i = 0; i < 23; i++) sclkPulse(w[i]);
    sData = w[23];
    #5 sClk = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (seen == 0 && updStrobe) begin
        seen = k;
        check(cfgWord == w, "R3 word with strobe", cfgWord, w);
      end else if (seen == 0) begin
        check(cfgWord == old, "R7 old word before strobe", cfgWord, old);
      end
    end
    check(seen >= 2 && seen <= 4, "R3 commit latency", 24'(seen), 24'd3);
    sClk = 1'b0;
    #10 csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_extra(input logic [23:0] w);
    int base;
    base = strobeCnt;
    sendWord(w, 33);
    check(cfgWord == w, "R4 extra bits ignored", cfgWord, w);
    check(strobeCnt == base + 1, "R4 single commit", 24'(strobeCnt - base), 24'd1);
  endtask

  task automatic t_abort(input logic [23:0] partial, input logic [23:0] w);
    logic [23:0] old;
    int base;
    old = cfgWord;
    base = strobeCnt;
    sendWord(partial, 10);
    check(cfgWord == old, "R5 short transfer discarded", cfgWord, old);
    check(strobeCnt == base, "R5 no strobe on abort", 24'(strobeCnt - base), 24'd0);
    sendWord(w, 24);
    check(cfgWord == w, "R5 counter restarted", cfgWord, w);
  endtask

  task automatic t_error();
    logic [23:0] w;
    w = pack(7'd2, 7'd40, 1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0);
    sendWord(w, 24);
    check(cfgWord == w, "R9 bad word still committed", cfgWord, w);
    check(cfgErr == 1'b1, "R9 low N flagged", {23'd0, cfgErr}, 24'd1);
    w = pack(7'd50, 7'd20, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    sendWord(w, 24);
    check(cfgErr == 1'b1, "R9 flag sticky", {23'd0, cfgErr}, 24'd1);
    doReset();
    check(cfgErr == 1'b0 && cfgWord == DEFW, "R1 reset clears flag", cfgWord, DEFW);
    w = pack(7'd50, 7'd20, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0) & ~24'h20_0000;
    sendWord(w, 24);
    check(cfgErr == 1'b1, "R9 reserved bit 21 low", {23'd0, cfgErr}, 24'd1);
    doReset();
    w = pack(7'd50, 7'd1, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    sendWord(w, 24);
    check(cfgErr == 1'b1, "R9 low M flagged", {23'd0, cfgErr}, 24'd1);
    doReset();
    w = pack(7'd3, 7'd3, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    sendWord(w, 24);
    check(cfgErr == 1'b0, "R9 N=M=3 accepted", {23'd0, cfgErr}, 24'd0);
  endtask

  initial begin
    t_reset();
    t_full(pack(7'd100, 7'd45, 1'b1, 2'd3, 2'd2, 1'b1, 1'b0, 1'b1));
    t_full(pack(7'd127, 7'd3, 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0));
    t_latency(pack(7'd77, 7'd99, 1'b1, 2'd2, 2'd3, 1'b0, 1'b0, 1'b1));
    t_extra(pack(7'd85, 7'd42, 1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0));
    t_abort(24'hFFFFFF, pack(7'd33, 7'd66, 1'b1, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0));
    check(wideCnt == 0, "R6 strobe one cycle wide", 24'(wideCnt), 24'd0);
    t_error();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule